// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel data buses, called side A and side B, and moves bytes between them. It holds one storage register for each direction. The forward register samples side A on the rising edge of its own capture clock. The reverse register samples side B on the rising edge of a second, independent capture clock. For each direction a path-select input decides whether the port being driven carries the opposite bus as it is now, or the byte stored earlier. One block can therefore pass data through in real time, hold a bus value for later, replay a stored byte onto either side, or mix these: it can store a byte while passing live data the other way.

A shared active-low output enable and a direction input decide which side, if either, the block drives. Pads are shown as three separate signals per side: an input, an output value and an output enable. A pad ring can then build the three-state buffers and the core stays fully synthesizable. The capture registers use a synchronous active-high reset. Each register applies the reset on its own capture clock edge.

Top module: `xcvr_bus_bridge`

## Requirements
- R1: While `rst` is high at a rising capture edge, that direction's stored byte becomes 0. The bench reads it back through the stored path.
- R2: On each rising edge of `clk_ab` with `rst` low, the forward register takes the value of `a_in`. `clk_ba` edges leave it unchanged.
- R3: On each rising edge of `clk_ba` with `rst` low, the reverse register takes the value of `b_in`. `clk_ab` edges leave it unchanged.
- R4: `b_oe` equals (not `oe_n`) and `dir`. `a_oe` equals (not `oe_n`) and (not `dir`). The two are never high together, and both are low whenever `oe_n` is 1.
- R5: When `b_oe` is high and `sel_ab` = 0 (live), `b_out` equals the current `a_in` with no clock edge in between.
- R6: When `b_oe` is high and `sel_ab` = 1 (stored), `b_out` equals the forward register.
- R7: When `a_oe` is high and `sel_ba` = 0 (live), `a_out` equals the current `b_in` with no clock edge in between.
- R8: When `a_oe` is high and `sel_ba` = 1 (stored), `a_out` equals the reverse register.
- R9: A side whose output enable is low presents 0 on its output value.
- R10: Captures happen whatever the values of `oe_n`, `dir` and the select inputs. A byte stored while both sides are disabled is replayed once that side is enabled with its select at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the forward (A to B) register |
| clk_ba | input | 1 | Capture clock of the reverse (B to A) register |
| rst | input | 1 | Synchronous active-high reset, applied on each capture clock |
| oe_n | input | 1 | Active-low output enable for both sides |
| dir | input | 1 | 1 drives side B, 0 drives side A |
| sel_ab | input | 1 | Source for side B: 0 live `a_in`, 1 stored forward byte |
| sel_ba | input | 1 | Source for side A: 0 live `b_in`, 1 stored reverse byte |
| a_in | input | BUS_W | Value seen on the side A pads |
| a_out | output | BUS_W | Value the block drives onto side A |
| a_oe | output | 1 | Drive enable for the side A pads |
| b_in | input | BUS_W | Value seen on the side B pads |
| b_out | output | BUS_W | Value the block drives onto side B |
| b_oe | output | 1 | Drive enable for the side B pads |

## Verification
The bound checker tests these rules at every capture edge: the two sides are never driven at once, a disabled side outputs zero, live paths follow their source bus, and the stored path replays the byte seen at the previous edge. The bench's scenarios are needed for the rest. They sweep every byte value against all sixteen settings of enable, direction and both selects, which shows that the live paths have no latency. They also show that the two registers are isolated from each other's clocks, and that a byte captured while both sides were disabled comes back intact once a side is enabled.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int BUS_W_DEF = 8;
    localparam int N_DIRS    = 2;
    localparam int DIR_AB    = 0;
    localparam int DIR_BA    = 1;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_e;

    typedef struct packed {
        logic drive_b;
        logic drive_a;
    } drive_t;

    function automatic drive_t decode_drive(input logic oe_n, input logic dir);
        drive_t d;
        d.drive_b = ~oe_n & dir;
        d.drive_a = ~oe_n & ~dir;
        return d;
    endfunction

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  src_e         sel,
    input  logic         en,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);

    always_comb begin
        if (!en) begin
            y = '0;
        end else if (sel == SRC_STORED) begin
            y = stored;
        end else begin
            y = live;
        end
    end

endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
    import xcvr_pkg::*;
(
    input  logic   oe_n,
    input  logic   dir,
    output drive_t drv
);

    always_comb begin
        drv = decode_drive(oe_n, dir);
    end

endmodule

// File: rtl/xcvr_bus_bridge.sv
module xcvr_bus_bridge
    import xcvr_pkg::*;
#(
    parameter int BUS_W = BUS_W_DEF
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [BUS_W-1:0] a_in,
    output logic [BUS_W-1:0] a_out,
    output logic             a_oe,
    input  logic [BUS_W-1:0] b_in,
    output logic [BUS_W-1:0] b_out,
    output logic             b_oe
);

    drive_t drv;

    xcvr_drive_ctl u_ctl (
        .oe_n (oe_n),
        .dir  (dir),
        .drv  (drv)
    );

    // Per-direction wiring: index DIR_AB feeds side B, DIR_BA feeds side A
    logic             cap_clk [N_DIRS];
    logic [BUS_W-1:0] src_bus [N_DIRS];
    logic [BUS_W-1:0] held    [N_DIRS];
    logic [BUS_W-1:0] path_y  [N_DIRS];
    src_e             path_sel[N_DIRS];
    logic             path_en [N_DIRS];

    always_comb begin
        cap_clk[DIR_AB]  = clk_ab;
        cap_clk[DIR_BA]  = clk_ba;
        src_bus[DIR_AB]  = a_in;
        src_bus[DIR_BA]  = b_in;
        path_sel[DIR_AB] = src_e'(sel_ab);
        path_sel[DIR_BA] = src_e'(sel_ba);
        path_en[DIR_AB]  = drv.drive_b;
        path_en[DIR_BA]  = drv.drive_a;
    end

    for (genvar g = 0; g < N_DIRS; g++) begin : g_path
        xcvr_store_reg #(.W(BUS_W)) u_reg (
            .clk (cap_clk[g]),
            .rst (rst),
            .d   (src_bus[g]),
            .q   (held[g])
        );

        xcvr_path_mux #(.W(BUS_W)) u_mux (
            .sel    (path_sel[g]),
            .en     (path_en[g]),
            .live   (src_bus[g]),
            .stored (held[g]),
            .y      (path_y[g])
        );
    end

    assign b_out = path_y[DIR_AB];
    assign a_out = path_y[DIR_BA];
    assign b_oe  = drv.drive_b;
    assign a_oe  = drv.drive_a;

endmodule

// File: rtl/xcvr_bus_bridge_chk.sv
module xcvr_bus_bridge_chk #(
    parameter int BUS_W = 8
) (
    input logic             clk_ab,
    input logic             clk_ba,
    input logic             rst,
    input logic             oe_n,
    input logic             dir,
    input logic             sel_ab,
    input logic             sel_ba,
    input logic [BUS_W-1:0] a_in,
    input logic [BUS_W-1:0] a_out,
    input logic             a_oe,
    input logic [BUS_W-1:0] b_in,
    input logic [BUS_W-1:0] b_out,
    input logic             b_oe
);

    // Shadows of the bus value seen at the previous capture edge
    logic             run_ab;
    logic             run_ba;
    logic [BUS_W-1:0] prev_a;
    logic [BUS_W-1:0] prev_b;

    always_ff @(posedge clk_ab) begin
        run_ab <= ~rst;
        prev_a <= a_in;
    end

    always_ff @(posedge clk_ba) begin
        run_ba <= ~rst;
        prev_b <= b_in;
    end

    a_r4_never_both: assert property (@(posedge clk_ab) disable iff (rst)
        !(a_oe && b_oe));

    a_r4_off_when_disabled: assert property (@(posedge clk_ba) disable iff (rst)
        oe_n |-> (!a_oe && !b_oe));

    a_r9_quiet_b: assert property (@(posedge clk_ab) disable iff (rst)
        !b_oe |-> (b_out == '0));

    a_r9_quiet_a: assert property (@(posedge clk_ba) disable iff (rst)
        !a_oe |-> (a_out == '0));

    a_r5_live_b: assert property (@(posedge clk_ab) disable iff (rst)
        (b_oe && !sel_ab) |-> (b_out == a_in));

    a_r7_live_a: assert property (@(posedge clk_ba) disable iff (rst)
        (a_oe && !sel_ba) |-> (a_out == b_in));

    a_r6_stored_b: assert property (@(posedge clk_ab) disable iff (rst)
        (run_ab === 1'b1 && b_oe && sel_ab) |-> (b_out == prev_a));

    a_r8_stored_a: assert property (@(posedge clk_ba) disable iff (rst)
        (run_ba === 1'b1 && a_oe && sel_ba) |-> (a_out == prev_b));

endmodule

bind xcvr_bus_bridge xcvr_bus_bridge_chk #(.BUS_W(BUS_W)) u_chk (
    .clk_ab (clk_ab),
    .clk_ba (clk_ba),
    .rst    (rst),
    .oe_n   (oe_n),
    .dir    (dir),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .a_in   (a_in),
    .a_out  (a_out),
    .a_oe   (a_oe),
    .b_in   (b_in),
    .b_out  (b_out),
    .b_oe   (b_oe)
);

// File: tb/sim_xcvr_bus_bridge.sv
module sim_xcvr_bus_bridge;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clk_ab = 1'b0;
    logic         clk_ba = 1'b0;
    logic         rst = 1'b1;
    logic         oe_n = 1'b1;
    logic         dir = 1'b0;
    logic         sel_ab = 1'b0;
    logic         sel_ba = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] a_out;
    logic [W-1:0] b_out;
    logic         a_oe;
    logic         b_oe;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [W-1:0] exp_ab = '0;
    logic [W-1:0] exp_ba = '0;

    xcvr_bus_bridge #(.BUS_W(W)) u0 (
        .clk_ab (clk_ab),
        .clk_ba (clk_ba),
        .rst    (rst),
        .oe_n   (oe_n),
        .dir    (dir),
        .sel_ab (sel_ab),
        .sel_ba (sel_ba),
        .a_in   (a_in),
        .a_out  (a_out),
        .a_oe   (a_oe),
        .b_in   (b_in),
        .b_out  (b_out),
        .b_oe   (b_oe)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks = checks + 1;
        if (act !== expv) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic pulse_ab();
        #1 clk_ab = 1'b1;
        #1 clk_ab = 1'b0;
        #1;
    endtask

    task automatic pulse_ba();
        #1 clk_ba = 1'b1;
        #1 clk_ba = 1'b0;
        #1;
    endtask

    task automatic check_all();
        logic eb;
        logic ea;
        logic [W-1:0] xb;
        logic [W-1:0] xa;
        eb = !oe_n && dir;
        ea = !oe_n && !dir;
        xb = eb ? (sel_ab ? exp_ab : a_in) : '0;
        xa = ea ? (sel_ba ? exp_ba : b_in) : '0;
        #1;
        chk("R4 b_oe", 32'(b_oe), 32'(eb));
        chk("R4 a_oe", 32'(a_oe), 32'(ea));
        if (!eb)         chk("R9 b_out", 32'(b_out), 32'(xb));
        else if (sel_ab) chk("R6 b_out", 32'(b_out), 32'(xb));
        else             chk("R5 b_out", 32'(b_out), 32'(xb));
        if (!ea)         chk("R9 a_out", 32'(a_out), 32'(xa));
        else if (sel_ba) chk("R8 a_out", 32'(a_out), 32'(xa));
        else             chk("R7 a_out", 32'(a_out), 32'(xa));
    endtask

    initial begin
        // R1: reset through both capture clocks
        a_in = 8'hA5; b_in = 8'h5A; rst = 1'b1;
        pulse_ab(); pulse_ba();
        rst = 1'b0;
        oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; #1;
        chk("R1 forward cleared", 32'(b_out), 32'h0);
        dir = 1'b0; sel_ba = 1'b1; #1;
        chk("R1 reverse cleared", 32'(a_out), 32'h0);

        // Full sweep of data values against every control setting
        for (int v = 0; v < 256; v++) begin
            a_in = W'(v);
            b_in = W'((v * 37 + 11) & 8'hFF);
            for (int c = 0; c < 16; c++) begin
                {oe_n, dir, sel_ab, sel_ba} = 4'(c);
                check_all();
            end
            if (v % 3 == 0) begin
                oe_n = v[0];
                pulse_ab();
                exp_ab = a_in;
            end
            if (v % 5 == 0) begin
                oe_n = v[1];
                pulse_ba();
                exp_ba = b_in;
            end
        end

        // R2 / R3: each register follows only its own clock
        oe_n = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
        a_in = 8'h3C; b_in = 8'hC3;
        pulse_ab(); exp_ab = 8'h3C;
        a_in = 8'h77; b_in = 8'h11;
        pulse_ba(); exp_ba = 8'h11;
        dir = 1'b1; #1;
        chk("R2 forward kept across clk_ba", 32'(b_out), 32'h3C);
        dir = 1'b0; #1;
        chk("R3 reverse captured b_in", 32'(a_out), 32'h11);
        b_in = 8'h99;
        pulse_ab(); exp_ab = 8'h77;
        #1;
        chk("R3 reverse kept across clk_ab", 32'(a_out), 32'h11);
        dir = 1'b1; #1;
        chk("R2 forward captured a_in", 32'(b_out), 32'h77);

        // R10: capture while both sides disabled, then replay
        oe_n = 1'b1; a_in = 8'hE1; b_in = 8'h1E;
        pulse_ab(); pulse_ba();
        exp_ab = 8'hE1; exp_ba = 8'h1E;
        a_in = 8'h00; b_in = 8'hFF; #1;
        chk("R10 disabled b_out", 32'(b_out), 32'h0);
        chk("R10 disabled a_out", 32'(a_out), 32'h0);
        oe_n = 1'b0; dir = 1'b1; #1;
        chk("R10 replay forward", 32'(b_out), 32'hE1);
        dir = 1'b0; #1;
        chk("R10 replay reverse", 32'(a_out), 32'h1E);

        // R1 again: reset mid-run clears only the clocked direction
        rst = 1'b1; pulse_ab(); rst = 1'b0; exp_ab = '0;
        dir = 1'b1; #1;
        chk("R1 forward reset", 32'(b_out), 32'h0);
        dir = 1'b0; #1;
        chk("R1 reverse untouched", 32'(a_out), 32'h1E);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule